// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the register side of an I/O interrupt controller. Software reaches it through only two 32-bit locations on a simple strobe bus. The first is a select register. The second is a data window whose meaning follows the value held in select. Through the window, software reaches an identification register, a read-only version word and an arbitration word. It also reaches a table of 64-bit redirection entries, one per input pin. Each entry is split into two 32-bit halves.

The delivery logic takes each entry's decoded fields straight from flattened output vectors: vector, delivery mode, destination mode, destination, trigger mode and mask. The delivery logic reports an accepted level-triggered interrupt by pulsing `pend_set` for that pin, which sets the pin's remote-pending flag. Software clears that flag by rewriting the lower half of the entry. The block emits two kinds of one-cycle pulse. One fires when a mask bit actually changes. The other fires whenever an entry half is written.

A two-state access machine handles reads. ACC_IDLE moves to ACC_RDATA when a read strobe is seen (transition RD_ACCEPT). ACC_RDATA stays in ACC_RDATA when another strobe arrives (RD_BACK_TO_BACK). It returns to ACC_IDLE otherwise (RD_DONE). Read data is valid while the machine sits in ACC_RDATA.

Top module: `ioredir_regs`

## Requirements
- R1: Address offset 0x00 (bus_addr[7:0]) is the select register. It is 8 bits wide, and a write keeps only wdata[7:0]. A read of offset 0x00 returns the select value in bits 7:0 with zeros above.
- R2: At window offset 0x10 with select 0x01, reads return the version word ((PINS-1) & 0xFF) << 16 | 0x11. This is 0x00170011 for 24 pins. Writes to this select change nothing.
- R3: Select 0x00 is the ID register. A window write loads only wdata[27:24]. A read returns the 4-bit ID in bits 27:24 and zeros elsewhere. Select 0x02 reads the same word, and writes through it are dropped.
- R4: A select S of 0x10 or above addresses entry (S-0x10)>>1. An odd S reads and writes entry bits 63:32, and an even S reads and writes bits 31:0. Bit 12 always reads 0. Bit 14 reads the remote-pending flag. No write can set bits 12 or 14, and all other bits read back as written.
- R5: A select that names no register reads all ones. This covers selects 0x03 to 0x0F and entry indices at or above PINS (select 0x40 and up for 24 pins). Writes through such a select change no state.
- R6: A one-cycle pend_set[i] sets the remote-pending flag of entry i. The flag is cleared only by a write to the lower half of entry i. A write to the upper half leaves it. If a set and a lower-half write to the same entry land in the same cycle, the clear wins.
- R7: Only bus_addr[7:0] is decoded. Offsets other than 0x00 and 0x10 read as zero, and writes to them are dropped.
- R8: Read data appears on bus_rdata with bus_rvalid high in the cycle after the bus_rd strobe. bus_rvalid is low in any cycle not preceded by a strobe.
- R9: A write that flips an entry's mask bit (bit 16) raises mchg_valid for one cycle, with mchg_pin set to the entry index. A write that leaves the mask unchanged raises no pulse.
- R10: Every write to either half of a valid entry raises ewr_valid for one cycle, with ewr_pin set to the entry index.
- R11: Reset sets every mask bit, clears every other entry bit and every remote-pending flag, and clears select and ID to zero.
- R12: The per-entry outputs follow the entry bits. The vector is bits 7:0, the delivery mode is bits 10:8, the destination mode is bit 11, the trigger mode is bit 15, the mask is bit 16 and the destination is bits 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid (one cycle after strobe) |
| pend_set | input | PINS | Per-pin remote-pending set pulses |
| ent_vector | output | PINS*8 | Vector of each entry |
| ent_dmode | output | PINS*3 | Delivery mode of each entry |
| ent_destmode | output | PINS | Destination mode of each entry |
| ent_dest | output | PINS*8 | Destination of each entry |
| ent_trig | output | PINS | Trigger mode of each entry |
| ent_mask | output | PINS | Mask bit of each entry |
| ent_pend | output | PINS | Remote-pending flag of each entry |
| mchg_valid | output | 1 | Mask-change pulse |
| mchg_pin | output | IDX_W | Entry whose mask changed |
| ewr_valid | output | 1 | Entry-write pulse |
| ewr_pin | output | IDX_W | Entry that was written |

## Verification
The assertions check four things on every cycle. Read-valid timing must follow the strobe. A mask pulse must only mark a real mask flip that a write caused, and masks must hold still when no write occurs. A remote-pending flag must never rise without a set pulse. Reset must leave every mask set.

Other behaviour is visible only in the bench's scenarios, because it depends on values that the assertions do not model. This covers the select-to-entry mapping, the half selection, the read-back value of every entry, the all-ones answer for unused selects, address aliasing through the low byte, the ID and version words, and clear-wins ordering when a set pulse meets a lower-half write.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

    // Bus offsets (low address byte)
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;

    // Select codes
    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL0 = 8'h10;

    // Lower-half bit positions
    localparam int B_STATUS = 12;
    localparam int B_PEND   = 14;
    localparam int B_TRIG   = 15;
    localparam int B_MASK   = 16;

    localparam logic [31:0] LO_RO_BITS = (32'd1 << B_STATUS) | (32'd1 << B_PEND);
    localparam logic [31:0] LO_RESET   = 32'd1 << B_MASK;

    localparam logic [7:0] VERSION_CODE = 8'h11;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_ENTRY,
        K_BAD
    } win_kind_e;

    typedef enum logic [0:0] {
        ACC_IDLE,
        ACC_RDATA
    } acc_state_e;

endpackage

// File: rtl/ioredir_decode.sv
module ioredir_decode
    import ioredir_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = $clog2(PINS)
) (
    input  logic [7:0]       off,
    input  logic [7:0]       sel,
    output logic             hit_sel,
    output logic             hit_win,
    output win_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             upper
);

    logic [7:0] raw_idx;

    assign hit_sel = (off == OFF_SEL);
    assign hit_win = (off == OFF_WIN);
    assign raw_idx = 8'(sel - SEL_TBL0) >> 1;
    assign idx     = raw_idx[IDX_W-1:0];
    assign upper   = sel[0];

    always_comb begin
        unique case (sel)
            SEL_ID:  kind = K_ID;
            SEL_VER: kind = K_VER;
            SEL_ARB: kind = K_ARB;
            default: begin
                if (sel >= SEL_TBL0 && int'(raw_idx) < PINS)
                    kind = K_ENTRY;
                else
                    kind = K_BAD;
            end
        endcase
    end

endmodule

// File: rtl/ioredir_table.sv
module ioredir_table
    import ioredir_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int IDX_W = $clog2(PINS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tbl_wr,
    input  logic [IDX_W-1:0]      tbl_idx,
    input  logic                  tbl_upper,
    input  logic [31:0]           tbl_wdata,
    input  logic [PINS-1:0]       pend_set,
    output logic [PINS-1:0][31:0] lo_word,
    output logic [PINS-1:0][31:0] hi_word,
    output logic [PINS-1:0]       pend,
    output logic                  mchg_valid,
    output logic [IDX_W-1:0]      mchg_pin,
    output logic                  ewr_valid,
    output logic [IDX_W-1:0]      ewr_pin
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PINS; i++) begin
                lo_word[i] <= LO_RESET;
                hi_word[i] <= '0;
            end
            pend       <= '0;
            mchg_valid <= 1'b0;
            mchg_pin   <= '0;
            ewr_valid  <= 1'b0;
            ewr_pin    <= '0;
        end else begin
            pend       <= pend | pend_set;
            mchg_valid <= 1'b0;
            ewr_valid  <= 1'b0;
            if (tbl_wr) begin
                ewr_valid <= 1'b1;
                ewr_pin   <= tbl_idx;
                if (tbl_upper) begin
                    hi_word[tbl_idx] <= tbl_wdata;
                end else begin
                    lo_word[tbl_idx] <= tbl_wdata & ~LO_RO_BITS;
                    pend[tbl_idx]    <= 1'b0;
                    if (tbl_wdata[B_MASK] != lo_word[tbl_idx][B_MASK]) begin
                        mchg_valid <= 1'b1;
                        mchg_pin   <= tbl_idx;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ioredir_regs.sv
module ioredir_regs
    import ioredir_pkg::*;
#(
    parameter int PINS   = 24,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = $clog2(PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [PINS-1:0]     pend_set,
    output logic [PINS*8-1:0]   ent_vector,
    output logic [PINS*3-1:0]   ent_dmode,
    output logic [PINS-1:0]     ent_destmode,
    output logic [PINS*8-1:0]   ent_dest,
    output logic [PINS-1:0]     ent_trig,
    output logic [PINS-1:0]     ent_mask,
    output logic [PINS-1:0]     ent_pend,
    output logic                mchg_valid,
    output logic [IDX_W-1:0]    mchg_pin,
    output logic                ewr_valid,
    output logic [IDX_W-1:0]    ewr_pin
);

    localparam logic [31:0] VER_WORD = {8'h00, 8'(PINS - 1), 8'h00, VERSION_CODE};

    logic [7:0]             sel_q;
    logic [3:0]             id_q;
    acc_state_e             state_q, state_d;
    logic                   hit_sel, hit_win, upper;
    win_kind_e              kind;
    logic [IDX_W-1:0]       idx;
    logic                   tbl_wr;
    logic [PINS-1:0][31:0]  lo_word, hi_word;
    logic [31:0]            rd_word;

    ioredir_decode #(.PINS(PINS), .IDX_W(IDX_W)) u_dec (
        .off     (bus_addr[7:0]),
        .sel     (sel_q),
        .hit_sel (hit_sel),
        .hit_win (hit_win),
        .kind    (kind),
        .idx     (idx),
        .upper   (upper)
    );

    assign tbl_wr = bus_wr && hit_win && (kind == K_ENTRY);

    ioredir_table #(.PINS(PINS), .IDX_W(IDX_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tbl_wr     (tbl_wr),
        .tbl_idx    (idx),
        .tbl_upper  (upper),
        .tbl_wdata  (bus_wdata),
        .pend_set   (pend_set),
        .lo_word    (lo_word),
        .hi_word    (hi_word),
        .pend       (ent_pend),
        .mchg_valid (mchg_valid),
        .mchg_pin   (mchg_pin),
        .ewr_valid  (ewr_valid),
        .ewr_pin    (ewr_pin)
    );

    // Select and ID registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else if (bus_wr) begin
            if (hit_sel)
                sel_q <= bus_wdata[7:0];
            else if (hit_win && kind == K_ID)
                id_q <= bus_wdata[27:24];
        end
    end

    // Read multiplexer
    always_comb begin
        rd_word = '0;
        if (hit_sel) begin
            rd_word = {24'd0, sel_q};
        end else if (hit_win) begin
            unique case (kind)
                K_ID, K_ARB: rd_word = {4'd0, id_q, 24'd0};
                K_VER:       rd_word = VER_WORD;
                K_ENTRY: begin
                    if (upper)
                        rd_word = hi_word[idx];
                    else
                        rd_word = lo_word[idx] | ({31'd0, ent_pend[idx]} << B_PEND);
                end
                default:     rd_word = '1;
            endcase
        end
    end

    // Access state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:  state_d = bus_rd ? ACC_RDATA : ACC_IDLE;
            ACC_RDATA: state_d = bus_rd ? ACC_RDATA : ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    // Access state machine: state register and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ACC_IDLE;
            bus_rdata <= '0;
        end else begin
            state_q <= state_d;
            if (bus_rd)
                bus_rdata <= rd_word;
        end
    end

    // Access state machine: outputs
    always_comb begin
        unique case (state_q)
            ACC_RDATA: bus_rvalid = 1'b1;
            default:   bus_rvalid = 1'b0;
        endcase
    end

    // Decoded per-entry fields
    for (genvar g = 0; g < PINS; g++) begin : g_fields
        assign ent_vector[g*8 +: 8]  = lo_word[g][7:0];
        assign ent_dmode[g*3 +: 3]   = lo_word[g][10:8];
        assign ent_destmode[g]       = lo_word[g][11];
        assign ent_trig[g]           = lo_word[g][B_TRIG];
        assign ent_mask[g]           = lo_word[g][B_MASK];
        assign ent_dest[g*8 +: 8]    = hi_word[g][31:24];
    end

endmodule

// File: rtl/ioredir_regs_chk.sv
module ioredir_regs_chk #(
    parameter int PINS  = 24,
    parameter int IDX_W = $clog2(PINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic             bus_rvalid,
    input logic [PINS-1:0]  pend_set,
    input logic [PINS-1:0]  ent_mask,
    input logic [PINS-1:0]  ent_pend,
    input logic             mchg_valid,
    input logic [IDX_W-1:0] mchg_pin,
    input logic             ewr_valid
);

    logic [PINS-1:0] prev_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_mask <= '1;
        else        prev_mask <= ent_mask;
    end

    a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    a_r9_pulse_marks_flip: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> (ent_mask[mchg_pin] != prev_mask[mchg_pin]));

    a_r9_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        mchg_valid |-> $past(bus_wr));

    a_r9_mask_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(ent_mask));

    a_r10_entry_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ewr_valid |-> $past(bus_wr));

    a_r6_pend_rises_on_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((ent_pend & ~$past(ent_pend) & ~$past(pend_set)) == '0));

    a_r11_reset_masks_set: assert property (@(posedge clk)
        !rst_n |=> (&ent_mask) && (ent_pend == '0));

endmodule

bind ioredir_regs ioredir_regs_chk #(.PINS(PINS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .pend_set   (pend_set),
    .ent_mask   (ent_mask),
    .ent_pend   (ent_pend),
    .mchg_valid (mchg_valid),
    .mchg_pin   (mchg_pin),
    .ewr_valid  (ewr_valid)
);

// File: tb/ioredir_regs_test.sv
`timescale 1ns/1ps
module ioredir_regs_test;

    localparam int PINS = 24;
    localparam int IDX_W = $clog2(PINS);
    localparam logic [11:0] A_SEL = 12'h000;
    localparam logic [11:0] A_WIN = 12'h010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_rvalid;
    logic [PINS-1:0] pend_set = '0;
    logic [PINS*8-1:0] ent_vector, ent_dest;
    logic [PINS*3-1:0] ent_dmode;
    logic [PINS-1:0] ent_destmode, ent_trig, ent_mask, ent_pend;
    logic mchg_valid, ewr_valid;
    logic [IDX_W-1:0] mchg_pin, ewr_pin;

    int n_run = 0, n_fail = 0;
    logic cap_m, cap_e;
    logic [IDX_W-1:0] cap_mp, cap_ep;
    logic [31:0] rv;
    logic rvld;

    always #2.5 clk = ~clk;

    ioredir_regs #(.PINS(PINS), .ADDR_W(12)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pend_set(pend_set), .ent_vector(ent_vector),
        .ent_dmode(ent_dmode), .ent_destmode(ent_destmode), .ent_dest(ent_dest),
        .ent_trig(ent_trig), .ent_mask(ent_mask), .ent_pend(ent_pend),
        .mchg_valid(mchg_valid), .mchg_pin(mchg_pin),
        .ewr_valid(ewr_valid), .ewr_pin(ewr_pin)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        cap_m = mchg_valid; cap_mp = mchg_pin;
        cap_e = ewr_valid;  cap_ep = ewr_pin;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        rv = bus_rdata; rvld = bus_rvalid;
    endtask

    function automatic logic [31:0] lo_pat(input int i);
        return (32'(i) * 32'h0913_57AD) ^ 32'hA5C3_0F00;
    endfunction

    function automatic logic [31:0] hi_pat(input int i);
        return (32'(i) * 32'h1357_9BDF) + 32'd5;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [PINS-1:0] snap_mask;
        logic [PINS*8-1:0] snap_vec;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        chk("R11 masks after reset", 32'(ent_mask), 32'(24'hFFFFFF));
        chk("R11 pend after reset", 32'(ent_pend), 32'd0);
        chk("R8 rvalid idle", 32'(bus_rvalid), 32'd0);
        rd(A_SEL);  chk("R11 select reset", rv, 32'd0);
        rd(A_WIN);  chk("R11 id reset", rv, 32'd0);
        wr(A_SEL, 32'h1A);
        rd(A_WIN);  chk("R11 entry5 lower reset", rv, 32'h0001_0000);

        // R1 select width
        wr(A_SEL, 32'hFFFF_FF37);
        rd(A_SEL);  chk("R1 select low byte", rv, 32'h0000_0037);
        chk("R8 rvalid after strobe", 32'(rvld), 32'd1);
        @(negedge clk); chk("R8 rvalid drops", 32'(bus_rvalid), 32'd0);

        // R2 version
        wr(A_SEL, 32'h01);
        rd(A_WIN);  chk("R2 version", rv, 32'h0017_0011);
        wr(A_WIN, 32'hFFFF_FFFF);
        rd(A_WIN);  chk("R2 version after write", rv, 32'h0017_0011);

        // R3 ID and arbitration
        wr(A_SEL, 32'h00);
        wr(A_WIN, 32'hFEDC_BA98);
        rd(A_WIN);  chk("R3 id load", rv, 32'h0E00_0000);
        wr(A_SEL, 32'h02);
        rd(A_WIN);  chk("R3 arb mirrors id", rv, 32'h0E00_0000);
        wr(A_WIN, 32'h0000_0000);
        wr(A_SEL, 32'h00);
        rd(A_WIN);  chk("R3 arb write dropped", rv, 32'h0E00_0000);

        // R4 R9 R10 R12 full table sweep
        for (int i = 0; i < PINS; i++) begin
            logic [31:0] lo, hi;
            lo = lo_pat(i); hi = hi_pat(i);
            wr(A_SEL, 32'h11 + 32'(2*i));
            wr(A_WIN, hi);
            chk("R10 upper write pulse", {cap_e, 31'(cap_ep)}, {1'b1, 31'(i)});
            chk("R9 no pulse on upper", 32'(cap_m), 32'd0);
            wr(A_SEL, 32'h10 + 32'(2*i));
            wr(A_WIN, lo);
            chk("R10 lower write pulse", {cap_e, 31'(cap_ep)}, {1'b1, 31'(i)});
            chk("R9 pulse iff mask flips", {cap_m, 31'(cap_m ? cap_mp : '0)},
                {~lo[16], 31'(lo[16] ? 0 : i)});
            rd(A_WIN);
            chk("R4 lower readback", rv, lo & ~32'h0000_5000);
            wr(A_SEL, 32'h11 + 32'(2*i));
            rd(A_WIN);
            chk("R4 upper readback", rv, hi);
            chk("R12 vector", 32'(ent_vector[i*8 +: 8]), 32'(lo[7:0]));
            chk("R12 delivery mode", 32'(ent_dmode[i*3 +: 3]), 32'(lo[10:8]));
            chk("R12 dest mode/trig/mask",
                {29'd0, ent_destmode[i], ent_trig[i], ent_mask[i]},
                {29'd0, lo[11], lo[15], lo[16]});
            chk("R12 destination", 32'(ent_dest[i*8 +: 8]), 32'(hi[31:24]));
        end

        // R9 mask flips and no-change rewrites
        for (int i = 0; i < PINS; i += 5) begin
            logic [31:0] nv;
            nv = lo_pat(i) ^ 32'h0001_0000;
            wr(A_SEL, 32'h10 + 32'(2*i));
            wr(A_WIN, nv);
            chk("R9 flip pulse", {cap_m, 31'(cap_mp)}, {1'b1, 31'(i)});
            wr(A_WIN, nv);
            chk("R9 same mask no pulse", 32'(cap_m), 32'd0);
        end

        // R5 unused selects
        for (int s = 3; s < 16; s++) begin
            wr(A_SEL, 32'(s));
            rd(A_WIN); chk("R5 unused low select", rv, 32'hFFFF_FFFF);
        end
        for (int s = 16 + 2*PINS; s < 256; s++) begin
            wr(A_SEL, 32'(s));
            rd(A_WIN); chk("R5 index beyond table", rv, 32'hFFFF_FFFF);
        end
        snap_mask = ent_mask; snap_vec = ent_vector;
        wr(A_SEL, 32'h40);
        wr(A_WIN, 32'h0000_0000);
        chk("R5 no entry pulse", 32'(cap_e), 32'd0);
        chk("R5 masks unchanged", 32'(ent_mask), 32'(snap_mask));
        chk("R5 vectors unchanged", 32'(ent_vector ^ snap_vec), 32'd0);

        // R7 other offsets and aliasing
        wr(A_SEL, 32'h12);
        rd(12'h004); chk("R7 offset 0x04 reads zero", rv, 32'd0);
        rd(12'h020); chk("R7 offset 0x20 reads zero", rv, 32'd0);
        wr(12'h008, 32'h55);
        rd(A_SEL);   chk("R7 dropped write", rv, 32'h12);
        rd(12'h310); chk("R7 window alias", rv, lo_pat(1) & ~32'h0000_5000);

        // R6 remote-pending
        @(negedge clk) pend_set = 24'h000008;
        @(negedge clk) pend_set = '0;
        chk("R6 pend set", 32'(ent_pend), 32'h8);
        wr(A_SEL, 32'h16);
        rd(A_WIN);   chk("R6 pend bit reads", rv, (lo_pat(3) & ~32'h5000) | 32'h4000);
        wr(A_SEL, 32'h17);
        wr(A_WIN, 32'h1234_5678);
        chk("R6 upper keeps pend", 32'(ent_pend[3]), 32'd1);
        wr(A_SEL, 32'h16);
        wr(A_WIN, 32'h0000_4021);
        chk("R6 lower clears pend", 32'(ent_pend[3]), 32'd0);
        rd(A_WIN);   chk("R6 bit14 not writable", rv, 32'h0000_0021);
        wr(A_SEL, 32'h18);
        @(negedge clk);
        bus_addr = A_WIN; bus_wdata = 32'h0000_0042; bus_wr = 1'b1; pend_set = 24'h000010;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; pend_set = '0;
        chk("R6 clear wins over set", 32'(ent_pend[4]), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule